// File: doc/BRIEF.md
# Latched serial-to-parallel shift register

This block turns a serial bit stream into a parallel word in two stages. Each shift strobe moves a chain of shift stages one place along. A separate storage strobe copies the whole chain at once into a storage register, and that register drives the parallel outputs. Because the outputs only change on a storage strobe, a new word can be shifted in while the previous word stays stable on the outputs.

The chain has an active-low clear. The clear empties the shift stages at once and has priority over shifting. It never touches the storage register. The active-low output enable lets the parallel outputs drive the storage contents, or puts them into the high-impedance state. The last shift stage also comes out on a cascade pin, which the output enable does not affect. Several blocks can be chained by connecting the cascade pin of one block to the serial input of the next.

Both strobes are single-cycle enables sampled on the rising edge of one system clock. The system reset is active low and asynchronous, and it clears both registers.

Top module: `sipo_latch_top`

## Requirements
- R1: While `rst_ni` is low, the shift stages and the storage register are all zero. After reset, with `oe_ni` low, `par_o` reads 0 and `cascade_o` reads 0.
- R2: When `shift_stb_i` is low and `clr_ni` is high, the shift stages keep their values whatever `ser_i` does.
- R3: While `clr_ni` is low, every shift stage reads zero in the same cycle: `cascade_o` is 0, and a storage strobe captures zero. A shift strobe in that cycle has no effect. After `clr_ni` returns high, the stages stay zero until new bits are shifted in. The clear never changes the storage register.
- R4: On a clock edge where `shift_stb_i` is high and `clr_ni` is high, `ser_i` enters stage 0 and stage k takes the old value of stage k-1. Stage k appears on bit k of `par_o` after a store. The last stage (index WIDTH-1) drives `cascade_o`, so the first bit shifted in reaches `cascade_o` after WIDTH shifts.
- R5: On a clock edge where `store_stb_i` is high, the storage register copies all shift stages. With no store strobe, the storage register holds its value.
- R6: When `oe_ni` is high, all bits of `par_o` are high-impedance. When `oe_ni` is low, `par_o` drives the storage register.
- R7: `cascade_o` follows the last shift stage whatever the value of `oe_ni`.
- R8: When both strobes are high on the same edge, the storage register captures the shift contents from before that shift.
- R9: With two blocks chained through `cascade_o`, shifting in 2*WIDTH bits and then giving one store strobe leaves the first WIDTH bits on the downstream block and the last WIDTH bits on the upstream block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Serial data into stage 0 |
| shift_stb_i | input | 1 | Shift strobe, one cycle per shift |
| clr_ni | input | 1 | Shift-stage clear, active low |
| store_stb_i | input | 1 | Storage strobe, copies the stages into the storage register |
| oe_ni | input | 1 | Parallel output enable, active low |
| par_o | output | WIDTH | Storage register contents, or high-impedance |
| cascade_o | output | 1 | Last shift stage, for chaining |

## Verification
The main function is tried with several input patterns:
- An asymmetric byte (0xB2). This shows whether bits are placed in the right order or mirrored.
- The same pattern with a toggling serial input and no strobes. This tells real shifting apart from stages that merely follow the input.
- Shift strobes with no store strobe. This tells storage hold apart from storage that tracks the stages.
- Both strobes on one edge. This tells pre-shift capture apart from post-shift capture.

A 16-bit word (0xC35A) is sent through two chained blocks. It shows whether the cascade pin passes the last stage from before the shift. It also shows whether the downstream block gets the first byte and the upstream block the last byte.

Clear is pulsed together with a shift strobe and then followed by a store. This tells clear priority and its immediate effect apart from clear that also wipes the storage register.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int unsigned SIPO_WIDTH = 8;

  typedef enum logic [1:0] {
    SH_HOLD  = 2'd0,
    SH_SHIFT = 2'd1,
    SH_CLEAR = 2'd2
  } sh_op_e;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain
  import sipo_pkg::*;
#(
  parameter int unsigned WIDTH = SIPO_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic             shift_stb_i,
  input  logic             clr_ni,
  output logic [WIDTH-1:0] stage_q_o,
  output logic [WIDTH-1:0] stage_eff_o
);
  sh_op_e           op;
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;

  always_comb begin
    if (!clr_ni)          op = SH_CLEAR;
    else if (shift_stb_i) op = SH_SHIFT;
    else                  op = SH_HOLD;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    logic src;
    if (g == 0) begin : g_head
      assign src = ser_i;
    end else begin : g_body
      assign src = stage_q[g-1];
    end

    always_comb begin
      unique case (op)
        SH_CLEAR: stage_d[g] = 1'b0;
        SH_SHIFT: stage_d[g] = src;
        default:  stage_d[g] = stage_q[g];
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= 1'b0;
      else         stage_q[g] <= stage_d[g];
    end
  end

  // clear is seen at once, not one cycle later
  assign stage_eff_o = clr_ni ? stage_q : '0;
  assign stage_q_o   = stage_q;
endmodule

// File: rtl/sipo_store_reg.sv
module sipo_store_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             store_stb_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q_o <= '0;
    else if (store_stb_i) q_o <= d_i;
  end
endmodule

// File: rtl/sipo_out_drv.sv
module sipo_out_drv #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             oe_ni,
  input  logic [WIDTH-1:0] data_i,
  output wire  [WIDTH-1:0] pad_o
);
  assign pad_o = oe_ni ? {WIDTH{1'bz}} : data_i;
endmodule

// File: rtl/sipo_latch_top.sv
module sipo_latch_top
  import sipo_pkg::*;
#(
  parameter int unsigned WIDTH = SIPO_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic             shift_stb_i,
  input  logic             clr_ni,
  input  logic             store_stb_i,
  input  logic             oe_ni,
  output wire  [WIDTH-1:0] par_o,
  output logic             cascade_o
);
  localparam int unsigned LAST = WIDTH - 1;

  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] shift_eff;
  logic [WIDTH-1:0] stor_q;

  sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ser_i       (ser_i),
    .shift_stb_i (shift_stb_i),
    .clr_ni      (clr_ni),
    .stage_q_o   (shift_q),
    .stage_eff_o (shift_eff)
  );

  // the store sees the contents from before the shift on the same edge
  sipo_store_reg #(.WIDTH(WIDTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .store_stb_i (store_stb_i),
    .d_i         (shift_eff),
    .q_o         (stor_q)
  );

  sipo_out_drv #(.WIDTH(WIDTH)) u_drv (
    .oe_ni  (oe_ni),
    .data_i (stor_q),
    .pad_o  (par_o)
  );

  assign cascade_o = shift_eff[LAST];
endmodule

// File: rtl/sipo_latch_chk.sv
module sipo_latch_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ser_i,
  input logic             shift_stb_i,
  input logic             clr_ni,
  input logic             store_stb_i,
  input logic [WIDTH-1:0] shift_q,
  input logic [WIDTH-1:0] shift_eff,
  input logic [WIDTH-1:0] stor_q,
  input logic             cascade_o
);
  AST_SHIFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !shift_stb_i) |=> $stable(shift_q)); // R2

  AST_CLR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clr_ni) |-> (cascade_o == 1'b0)); // R3

  AST_SHIFT_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && shift_stb_i) |=>
      (shift_q[WIDTH-1:1] == $past(shift_q[WIDTH-2:0])) && (shift_q[0] == $past(ser_i))); // R4

  AST_STORE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !store_stb_i |=> $stable(stor_q)); // R5

  AST_STORE_PRESHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_stb_i |=> (stor_q == $past(shift_eff))); // R8
endmodule

bind sipo_latch_top sipo_latch_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ser_i       (ser_i),
  .shift_stb_i (shift_stb_i),
  .clr_ni      (clr_ni),
  .store_stb_i (store_stb_i),
  .shift_q     (shift_q),
  .shift_eff   (shift_eff),
  .stor_q      (stor_q),
  .cascade_o   (cascade_o)
);

// File: tb/sipo_latch_top_tb_top.sv
module sipo_latch_top_tb_top;
  localparam int W = 8;
  localparam logic [W-1:0] PULL = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser = 1'b0, sh = 1'b0, clr_n = 1'b1, st = 1'b0, oe_n = 1'b0;
  wire  [W-1:0] bus0, bus1;
  logic casc0, casc1;

  always #10 clk = ~clk;

  // a bench driver that shows when the block releases the bus
  assign bus0 = oe_n ? PULL : {W{1'bz}};
  assign bus1 = oe_n ? PULL : {W{1'bz}};

  sipo_latch_top #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .shift_stb_i(sh), .clr_ni(clr_n),
    .store_stb_i(st), .oe_ni(oe_n), .par_o(bus0), .cascade_o(casc0));

  sipo_latch_top #(.WIDTH(W)) dut_casc_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(casc0), .shift_stb_i(sh), .clr_ni(clr_n),
    .store_stb_i(st), .oe_ni(oe_n), .par_o(bus1), .cascade_o(casc1));

  typedef struct {
    logic [W-1:0] p0;
    logic [W-1:0] p1;
    logic         c0;
    logic         c1;
    string        tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] m0 = '0, m1 = '0, s0 = '0, s1 = '0;

  // driver: applies inputs at negedge and pushes expected post-edge result
  task automatic step(input logic ser_v, input logic sh_v, input logic st_v,
                      input logic clr_v, input logic oe_v, input string tag);
    logic [W-1:0] e0, e1;
    exp_t x;
    @(negedge clk);
    ser = ser_v; sh = sh_v; st = st_v; clr_n = clr_v; oe_n = oe_v;
    e0 = clr_v ? m0 : '0;
    e1 = clr_v ? m1 : '0;
    if (st_v) begin s0 = e0; s1 = e1; end
    if (!clr_v) begin m0 = '0; m1 = '0; end
    else if (sh_v) begin
      m1 = {m1[W-2:0], e0[W-1]};
      m0 = {m0[W-2:0], ser_v};
    end
    x.p0 = oe_v ? PULL : s0;
    x.p1 = oe_v ? PULL : s1;
    x.c0 = clr_v ? m0[W-1] : 1'b0;
    x.c1 = clr_v ? m1[W-1] : 1'b0;
    x.tag = tag;
    q.push_back(x);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      n_cmp++;
      if (bus0 !== x.p0 || bus1 !== x.p1 || casc0 !== x.c0 || casc1 !== x.c1) begin
        n_bad++;
        $display("FAIL %s: got par %h/%h casc %b/%b, exp par %h/%h casc %b/%b",
                 x.tag, bus0, bus1, casc0, casc1, x.p0, x.p1, x.c0, x.c1);
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, exp completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] pat;
    logic [2*W-1:0] word;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 1, 0, "R1 reset state");

    pat = 8'hB2;
    for (int i = W - 1; i >= 0; i--) step(pat[i], 1, 0, 1, 0, "R4 R5 shift without store");
    step(0, 0, 1, 1, 0, "R4 R5 store shifted pattern");
    for (int i = 0; i < 4; i++) step(i[0], 0, 0, 1, 0, "R2 hold without strobe");
    step(0, 0, 1, 1, 0, "R2 store after idle");

    step(0, 0, 0, 1, 1, "R6 outputs released");
    step(1, 1, 0, 1, 1, "R7 cascade with oe high");
    step(0, 0, 0, 1, 0, "R6 outputs driven again");

    step(1, 1, 0, 0, 0, "R3 clear beats shift");
    step(0, 0, 0, 1, 0, "R3 stages empty after clear");
    step(0, 0, 1, 1, 0, "R3 store captures cleared stages");

    pat = 8'h6C;
    for (int i = W - 1; i >= 0; i--) step(pat[i], 1, 0, 1, 0, "R4 load second pattern");
    step(1, 0, 1, 0, 0, "R3 store during clear");
    for (int i = W - 1; i >= 0; i--) step(pat[i], 1, 0, 1, 0, "R4 reload pattern");
    step(1, 1, 1, 1, 0, "R8 simultaneous strobes");
    step(0, 0, 0, 1, 0, "R8 result held");

    word = 16'hC35A;
    for (int i = 2 * W - 1; i >= 0; i--) step(word[i], 1, 0, 1, 0, "R9 cascade shift");
    step(0, 0, 1, 1, 0, "R9 cascade store");
    step(0, 0, 0, 1, 0, "R9 cascade held");
    if (s1 !== word[2*W-1:W] || s0 !== word[W-1:0]) begin
      n_bad++;
      $display("FAIL R9 model: got %h%h, exp %h", s1, s0, word);
    end
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule